// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block models the write side of a byte-wide parallel EEPROM that has a page mode. It runs on one clock and samples active-low chip-enable and write-enable strobes with an address bus and a data bus. Each write-enable low pulse loads one byte into a temporary page buffer. A valid bitmap records which offsets of the page have been loaded.

A load window opens on every rising edge of write-enable and restarts with the next pulse. When write-enable stays high for the whole window, the stored page is committed to the on-chip storage array. The commit erases every loaded cell and then programs it. A busy flag stays high for the whole commit, and write pulses are ignored while it is high. Cells that were not loaded are left untouched.

A read port exposes the storage array so that committed contents can be observed. All timing limits are parameters counted in clock cycles.

Top module: `eeprom_page_writer`

## Requirements
- R1: One commit writes between 1 and 2**PAGE_BITS bytes. The commit starts only after a byte was loaded. `busy` rises exactly BLC_CYC cycles after the clock edge at which `we_n` is first sampled high at the end of the last load pulse, provided `we_n` stays high in that time.
- R2: The target page is `addr[ADDR_W-1:PAGE_BITS]`, taken on the last qualified falling edge of `we_n` before the commit. Page bits presented on earlier pulses are discarded.
- R3: The byte offset is `addr[PAGE_BITS-1:0]`, sampled with `din` on the edge where `we_n` returns high. Offsets may arrive in any order. Loading an offset again replaces its buffered byte.
- R4: Each rising edge of `we_n` restarts the load window. A page of any length in time keeps loading as long as every gap between pulses is shorter than BLC_CYC cycles.
- R5: The commit erases every loaded cell to all ones before any cell is programmed. Erase lasts ERASE_CYC cycles and programming lasts PROG_CYC cycles.
- R6: Only loaded cells of the target page change. All other storage cells keep their contents.
- R7: `busy` stays high for exactly ERASE_CYC+PROG_CYC cycles per commit.
- R8: A write pulse whose falling edge arrives while `busy` is high loads nothing and changes neither the page nor the bitmap.
- R9: A pulse with `ce_n` high at either edge loads nothing and does not start a commit.
- R10: After a commit the bitmap is empty. The next commit rewrites only the bytes loaded after it.
- R11: After reset `busy` is low and every storage cell reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address: page bits above the offset bits |
| din | input | DATA_W | Write data |
| busy | output | 1 | High during the erase and program phases |
| rd_addr | input | ADDR_W | Storage read address |
| rd_data | output | DATA_W | Storage contents at `rd_addr` |

## Verification
On every cycle, the assertions check several orderings. Loads never happen while busy. The bitmap and page register stay frozen during a commit, and the bitmap is empty when busy falls. A commit never starts with an empty buffer or while write-enable is low. Programming is always entered from erase, and the load timer stays inside its window. Only the bench scenarios can show the behaviour that depends on stored values: which page wins across pulses, repeated offsets, the exact start cycle and length of busy, the all-ones state of cells between the phases, and untouched cells keeping their data across two commits. A behavioural model in the bench tracks busy and the storage contents cycle by cycle for this purpose.

// File: rtl/epw_pkg.sv
package epw_pkg;
   typedef enum logic [1:0] {
      EPW_IDLE,
      EPW_LOAD,
      EPW_ERASE,
      EPW_PROG
   } epw_state_e;
endpackage

// File: rtl/epw_strobe.sv
module epw_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic we_n,
   input  logic ce_n,
   input  logic busy,
   output logic open_stb,
   output logic load_stb
);
   logic we_q;
   logic armed_q;

   // qualified falling edge opens a load; only the matching rising edge loads
   assign open_stb = we_q & ~we_n & ~ce_n & ~busy;
   assign load_stb = armed_q & ~we_q & we_n & ~ce_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q    <= 1'b1;
         armed_q <= 1'b0;
      end else begin
         we_q <= we_n;
         if (open_stb)
            armed_q <= 1'b1;
         else if (!we_q && we_n)
            armed_q <= 1'b0;
      end
   end

   AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |-> !busy); // R8
endmodule

// File: rtl/epw_page_buffer.sv
module epw_page_buffer #(
   parameter int DATA_W    = 8,
   parameter int PAGE_BITS = 7,
   parameter int PG_W      = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 open_stb,
   input  logic                 load_stb,
   input  logic                 busy,
   input  logic                 clr,
   input  logic [PG_W-1:0]      pg_in,
   input  logic [PAGE_BITS-1:0] off_in,
   input  logic [DATA_W-1:0]    din,
   input  logic [PAGE_BITS-1:0] rd_slot,
   output logic                 slot_valid,
   output logic [DATA_W-1:0]    slot_data,
   output logic [PG_W-1:0]      page_q,
   output logic                 any_valid
);
   localparam int SLOTS = 1 << PAGE_BITS;

   logic [DATA_W-1:0] slot_mem [SLOTS];
   logic [SLOTS-1:0]  valid_q;

   always_ff @(posedge clk) begin
      if (load_stb)
         slot_mem[off_in] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         page_q  <= '0;
      end else begin
         if (open_stb)
            page_q <= pg_in;
         if (clr)
            valid_q <= '0;
         else if (load_stb)
            valid_q[off_in] <= 1'b1;
      end
   end

   assign slot_valid = valid_q[rd_slot];
   assign slot_data  = slot_mem[rd_slot];
   assign any_valid  = |valid_q;

   AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(valid_q)); // R8
   AST_MAP_EMPTY_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (valid_q == '0)); // R10
   AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(page_q)); // R2
endmodule

// File: rtl/epw_sequencer.sv
module epw_sequencer
   import epw_pkg::*;
#(
   parameter int BLC_CYC   = 8,
   parameter int ERASE_CYC = 136,
   parameter int PROG_CYC  = 136,
   parameter int PAGE_BITS = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we_n,
   input  logic                 load_stb,
   input  logic                 slot_valid,
   output logic                 busy,
   output logic                 wr_en,
   output logic                 wr_erase,
   output logic                 clr,
   output logic [PAGE_BITS-1:0] slot_idx
);
   localparam int SLOTS  = 1 << PAGE_BITS;
   localparam int PH_MAX = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
   localparam int TMR_W  = $clog2(BLC_CYC + 1);
   localparam int PC_W   = $clog2(PH_MAX + 1);

   if (BLC_CYC < 1) begin : g_bad_blc
      $error("BLC_CYC must be at least 1");
   end
   if (ERASE_CYC < SLOTS || PROG_CYC < SLOTS) begin : g_bad_phase
      $error("each phase must cover every slot");
   end

   epw_state_e      state_q;
   logic [TMR_W-1:0] tmr_q;
   logic [PC_W-1:0]  pc_q;
   logic             in_range;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= EPW_IDLE;
         tmr_q   <= '0;
         pc_q    <= '0;
      end else begin
         unique case (state_q)
            EPW_IDLE: begin
               if (load_stb) begin
                  state_q <= EPW_LOAD;
                  tmr_q   <= '0;
               end
            end
            EPW_LOAD: begin
               if (load_stb || !we_n)
                  tmr_q <= '0;
               else if (tmr_q == TMR_W'(BLC_CYC - 1)) begin
                  state_q <= EPW_ERASE;
                  pc_q    <= '0;
               end else
                  tmr_q <= tmr_q + 1'b1;
            end
            EPW_ERASE: begin
               if (pc_q == PC_W'(ERASE_CYC - 1)) begin
                  state_q <= EPW_PROG;
                  pc_q    <= '0;
               end else
                  pc_q <= pc_q + 1'b1;
            end
            EPW_PROG: begin
               if (pc_q == PC_W'(PROG_CYC - 1))
                  state_q <= EPW_IDLE;
               else
                  pc_q <= pc_q + 1'b1;
            end
            default: state_q <= EPW_IDLE;
         endcase
      end
   end

   assign busy     = (state_q == EPW_ERASE) || (state_q == EPW_PROG);
   assign in_range = pc_q < PC_W'(SLOTS);
   assign slot_idx = pc_q[PAGE_BITS-1:0];
   assign wr_en    = busy && in_range && slot_valid;
   assign wr_erase = (state_q == EPW_ERASE);
   assign clr      = (state_q == EPW_PROG) && (pc_q == PC_W'(PROG_CYC - 1));

   AST_ERASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == EPW_PROG && $past(state_q) != EPW_PROG) |-> $past(state_q) == EPW_ERASE); // R5
   AST_QUIET_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(we_n)); // R1
   AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == EPW_LOAD) |-> (tmr_q < TMR_W'(BLC_CYC))); // R4
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 8,
   parameter int PAGE_BITS = 7,
   parameter int BLC_CYC   = 8,
   parameter int ERASE_CYC = 136,
   parameter int PROG_CYC  = 136,
   parameter bit REG_RD    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              busy,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int PG_W  = ADDR_W - PAGE_BITS;
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W <= PAGE_BITS) begin : g_bad_addr
      $error("ADDR_W must exceed PAGE_BITS");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic                 open_stb, load_stb;
   logic                 slot_valid, any_valid;
   logic [DATA_W-1:0]    slot_data;
   logic [PG_W-1:0]      page_q;
   logic                 mem_we, wr_erase, clr;
   logic [PAGE_BITS-1:0] slot_idx;
   logic [DATA_W-1:0]    mem_q [DEPTH];

   epw_strobe u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_n     (we_n),
      .ce_n     (ce_n),
      .busy     (busy),
      .open_stb (open_stb),
      .load_stb (load_stb)
   );

   epw_page_buffer #(
      .DATA_W    (DATA_W),
      .PAGE_BITS (PAGE_BITS),
      .PG_W      (PG_W)
   ) u_buffer (
      .clk        (clk),
      .rst_n      (rst_n),
      .open_stb   (open_stb),
      .load_stb   (load_stb),
      .busy       (busy),
      .clr        (clr),
      .pg_in      (addr[ADDR_W-1:PAGE_BITS]),
      .off_in     (addr[PAGE_BITS-1:0]),
      .din        (din),
      .rd_slot    (slot_idx),
      .slot_valid (slot_valid),
      .slot_data  (slot_data),
      .page_q     (page_q),
      .any_valid  (any_valid)
   );

   epw_sequencer #(
      .BLC_CYC   (BLC_CYC),
      .ERASE_CYC (ERASE_CYC),
      .PROG_CYC  (PROG_CYC),
      .PAGE_BITS (PAGE_BITS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_n       (we_n),
      .load_stb   (load_stb),
      .slot_valid (slot_valid),
      .busy       (busy),
      .wr_en      (mem_we),
      .wr_erase   (wr_erase),
      .clr        (clr),
      .slot_idx   (slot_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem_q[i] <= '0;
      end else if (mem_we) begin
         mem_q[{page_q, slot_idx}] <= wr_erase ? {DATA_W{1'b1}} : slot_data;
      end
   end

   if (REG_RD) begin : g_rd_reg
      always_ff @(posedge clk) rd_data <= mem_q[rd_addr];
   end else begin : g_rd_comb
      assign rd_data = mem_q[rd_addr];
   end

   AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy); // R6
   AST_START_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> any_valid); // R1
endmodule

// File: tb/eeprom_page_writer_bench.sv
`timescale 1ns/1ps
module eeprom_page_writer_bench;
   localparam int AW = 11, DW = 8, PB = 7;
   localparam int BLC = 8, ERC = 136, PRC = 136;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic busy;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_data;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;
   bit hold = 1'b0;
   logic [AW-1:0] probe_addr = '0, scan_ptr = '0;

   always #5 clk = ~clk;

   eeprom_page_writer #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(PB), .BLC_CYC(BLC),
      .ERASE_CYC(ERC), .PROG_CYC(PRC), .REG_RD(1'b0)) u_eeprom_page_writer (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
      .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data));

   always_comb rd_addr = hold ? probe_addr : scan_ptr;
   always @(negedge clk) scan_ptr <= scan_ptr + 1'b1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int ms = 0, tmr = 0, cnt = 0, page = 0;
   bit prev_we = 1'b1, armed = 1'b0;
   logic [7:0] pbuf [int];
   logic [7:0] mmem [DEPTH];

   always @(posedge clk) begin
      bit bz, opn, rse, dis;
      if (!rst_n) begin
         ms = 0; tmr = 0; cnt = 0; page = 0; prev_we = 1; armed = 0;
         pbuf.delete();
         for (int i = 0; i < DEPTH; i++) mmem[i] = 8'h00;
      end else begin
         bz  = (ms >= 2);
         opn = prev_we && !we_n && !ce_n && !bz;
         rse = armed && !prev_we && we_n && !ce_n;
         dis = !prev_we && we_n;
         if (ms < 2) begin
            if (opn) page = int'(addr) >> PB;
            if (rse) begin
               pbuf[int'(addr) % (1 << PB)] = din;
               ms = 1; tmr = 0;
            end else if (ms == 1) begin
               if (!we_n) tmr = 0;
               else if (tmr == BLC - 1) begin ms = 2; cnt = 0; end
               else tmr++;
            end
         end else if (ms == 2) begin
            if (cnt < (1 << PB) && pbuf.exists(cnt)) mmem[page * (1 << PB) + cnt] = 8'hFF;
            if (cnt == ERC - 1) begin ms = 3; cnt = 0; end else cnt++;
         end else begin
            if (cnt < (1 << PB) && pbuf.exists(cnt)) mmem[page * (1 << PB) + cnt] = pbuf[cnt];
            if (cnt == PRC - 1) begin ms = 0; pbuf.delete(); end else cnt++;
         end
         if (opn) armed = 1; else if (dis) armed = 0;
         prev_we = we_n;
      end
   end

   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk(busy == (ms >= 2), "R7 busy vs model", int'(busy), int'(ms >= 2));
         chk(rd_data == mmem[rd_addr], "R6 storage vs model", int'(rd_data), int'(mmem[rd_addr]));
      end
   end

   task automatic pulse(input int a, input int d, input bit c, input int gap);
      @(negedge clk);
      addr = AW'(a); din = DW'(d); ce_n = c; we_n = 1'b0;
      repeat (2) @(negedge clk);
      we_n = 1'b1;
      repeat (gap) @(negedge clk);
   endtask

   task automatic peek(input int a, input int exp, input string tag);
      @(negedge clk);
      probe_addr = AW'(a); hold = 1'b1;
      #1;
      chk(rd_data == DW'(exp), tag, int'(rd_data), exp);
      hold = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      int blen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(busy == 1'b0, "R11 busy after reset", int'(busy), 0);
      peek(0, 8'h00, "R11 cell 0 after reset");
      peek(DEPTH - 1, 8'h00, "R11 last cell after reset");

      // R2 R3: page taken from last pulse, offsets mixed, offset 5 reloaded
      pulse(1 * 128 + 5,   8'h11, 1'b0, 1);
      pulse(2 * 128 + 0,   8'h22, 1'b0, 2);
      pulse(7 * 128 + 127, 8'h33, 1'b0, 1);
      pulse(3 * 128 + 5,   8'h44, 1'b0, 0);
      for (int k = 1; k <= BLC + 1; k++) begin
         @(negedge clk); #1;
         if (k == BLC) chk(busy == 1'b0, "R1 busy low before window ends", int'(busy), 0);
         if (k == BLC + 1) chk(busy == 1'b1, "R1 busy rises after window", int'(busy), 1);
      end
      repeat (ERC - 1) @(negedge clk);
      peek(3 * 128 + 5, 8'hFF, "R5 loaded cell erased before program");
      peek(3 * 128 + 1, 8'h00, "R6 unloaded cell untouched by erase");
      wait_idle();
      peek(3 * 128 + 5,   8'h44, "R3 reloaded offset keeps last byte");
      peek(3 * 128 + 0,   8'h22, "R2 byte lands in last page");
      peek(3 * 128 + 127, 8'h33, "R3 top offset");
      peek(3 * 128 + 1,   8'h00, "R6 unloaded neighbour");
      peek(1 * 128 + 5,   8'h00, "R2 earlier page untouched");

      // R4 R1: full page, long in time, gaps just inside window
      for (int o = 127; o >= 0; o--) pulse(9 * 128 + o, o ^ 8'h5A, 1'b0, BLC - 2);
      chk(busy == 1'b0, "R4 no commit while pulses keep coming", int'(busy), 0);
      while (!busy) @(negedge clk);
      #1;
      blen = 0;
      // R8: pulse during busy
      pulse(12 * 128 + 9, 8'h77, 1'b0, 1);
      while (busy) begin blen++; @(negedge clk); #1; end
      blen += 5;
      repeat (BLC + 5) @(negedge clk);
      #1;
      chk(busy == 1'b0, "R8 pulse during busy starts nothing", int'(busy), 0);
      peek(12 * 128 + 9, 8'h00, "R8 pulse during busy not written");
      peek(9 * 128 + 0,   8'h5A, "R1 full page slot 0");
      peek(9 * 128 + 64,  64 ^ 8'h5A, "R1 full page slot 64");
      peek(9 * 128 + 127, 127 ^ 8'h5A, "R1 full page slot 127");

      // R7: busy length measured on a fresh commit
      pulse(4 * 128 + 2, 8'hA5, 1'b0, 0);
      while (!busy) @(negedge clk);
      #1;
      blen = 0;
      while (busy) begin blen++; @(negedge clk); #1; end
      chk(blen == ERC + PRC, "R7 busy length", blen, ERC + PRC);

      // R9: deselected pulse
      pulse(12 * 128 + 10, 8'h66, 1'b1, 0);
      repeat (BLC + 5) @(negedge clk);
      #1;
      chk(busy == 1'b0, "R9 deselected pulse starts nothing", int'(busy), 0);
      peek(12 * 128 + 10, 8'h00, "R9 deselected pulse not written");

      // R10: new commit on page 3 touches only the new byte
      pulse(3 * 128 + 0, 8'h99, 1'b0, 0);
      while (!busy) @(negedge clk);
      wait_idle();
      peek(3 * 128 + 0,   8'h99, "R10 new byte written");
      peek(3 * 128 + 5,   8'h44, "R10 earlier byte not rewritten");
      peek(3 * 128 + 127, 8'h33, "R10 earlier top byte kept");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_tests++;
      $display("FAIL R7 watchdog expired: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule